// File: doc/BRIEF.md
# Timer counter with match and capture

This block is a general-purpose 32-bit timer/counter reached through a simple word-addressed register bus. A main counter advances either on a programmable divided clock or on synchronized edges of one of four external inputs. Four compare channels watch the counter. On a hit, each can flag an interrupt, wrap the counter to zero or halt it. Each compare channel also drives one external output pin, which it can set, clear or toggle.

Four capture channels snapshot the counter when their own input shows a chosen edge. They can raise an interrupt flag when they do. Every flag sits in one sticky status word and is cleared by writing a one to it. The single interrupt line is high whenever any flag is set.

Software reads and writes the registers in one cycle. Reads are combinational from the word address. A write takes effect at the clock edge that samples it.

Top module: `tmr_match_cap`

## Requirements
- R1: After reset every register reads zero, and irq and match_out are low.
- R2: The control register at word 1 uses bit 0 as run enable and bit 1 as hold. While hold is set, the counter (word 2) and the divider count (word 4) stay at zero.
- R3: When the mode bits are 0 the block is in timer mode. The divider count then rises by one on every enabled clock. When it equals the divider limit (word 3), it returns to zero and the counter advances by one. After k enabled clocks the counter reads k/(P+1) and the divider count reads k mod (P+1).
- R4: Bit 3n+1 of the compare control word (word 5) makes compare channel n wrap the counter. The counter holds the compare value (words 6 to 9) for one full count period and becomes zero at the next count event.
- R5: Bit 3n+2 of the compare control word halts the counter by clearing the run enable at the count event where the counter reaches compare value n.
- R6: A compare hit on channel n sets status bit n only when bit 3n of the compare control word is set.
- R7: Bits 3:0 of the output word (word 15) drive match_out. Bits 2n+5:2n+4 choose what a compare hit on channel n does to output n: 0 nothing, 1 clear, 2 set, 3 toggle.
- R8: Each capture channel n watches cap_in[n] through a two-flop synchronizer. Bit 3n of the capture control word (word 10) enables capture on a rising edge and bit 3n+1 on a falling edge. Both may be set. On a selected edge the counter is copied into capture word 11+n. An edge that is not selected leaves the capture word unchanged.
- R9: Bit 3n+2 of the capture control word makes a capture on channel n set status bit 4+n.
- R10: Writing the status word (word 0) clears exactly the bits written as one and leaves the others set. irq is the OR of all status bits.
- R11: Mode word 28 bits 1:0 select the count source: 1 counts rising edges, 2 falling edges, and 3 both edges of input cap_in[bits 3:2]. The divider does not take part in these modes.
- R12: A bus write to word 2 or word 4 loads the counter or the divider count directly. Other word addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cap_in | input | 4 | External capture / count inputs |
| match_out | output | 4 | External compare outputs |
| irq | output | 1 | Interrupt, OR of all status flags |

## Verification
The embedded assertions check four things on every cycle:
- hold forces the counter and divider count to zero;
- without a direct load, the counter only stays put, steps by one or drops to zero, and a wrap hit always produces zero;
- a halting hit always clears the enable;
- status flags never drop without a clearing write, and a capture word never changes without a capture event.

Only the bench's scenarios can show the rest, because each depends on a sequence of stimulus:
- the exact divide ratio for random divider limits;
- the one-period dwell at the compare value;
- the per-channel masking of flags;
- the four output actions;
- which edges capture or count;
- the selection of the counting input.

// File: rtl/tmr_match_cap.sv
module tmr_match_cap #(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [3:0]    cap_in,
  output logic [3:0]    match_out,
  output logic          irq
);
  localparam int NCH = 4;
  localparam logic [AW-1:0] A_FLG  = AW'(0);
  localparam logic [AW-1:0] A_CTL  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_PRE  = AW'(3);
  localparam logic [AW-1:0] A_PCNT = AW'(4);
  localparam logic [AW-1:0] A_MCTL = AW'(5);
  localparam logic [AW-1:0] A_MV0  = AW'(6);
  localparam logic [AW-1:0] A_CCTL = AW'(10);
  localparam logic [AW-1:0] A_CV0  = AW'(11);
  localparam logic [AW-1:0] A_EXT  = AW'(15);
  localparam logic [AW-1:0] A_MODE = AW'(28);

  logic [2*NCH-1:0] flg_q, flg_nxt;
  logic             en_q, hold_q;
  logic [CW-1:0]    cnt_q, pre_q, pcnt_q, cnt_inc;
  logic [3*NCH-1:0] mctl_q, cctl_q;
  logic [CW-1:0]    mv_q [NCH];
  logic [CW-1:0]    cv_q [NCH];
  logic [NCH-1:0]   ext_q, ext_nxt;
  logic [2*NCH-1:0] act_q;
  logic [3:0]       mode_q;
  logic [NCH-1:0]   s1, s2, s3, rise, fall, eq, mhit, cap_evt;
  logic             run, pre_hit, cnt_edge, tick, rst_hit, stop_hit;
  logic [NCH-1:0]   mint, cint;

  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign run      = en_q & ~hold_q;
  assign pre_hit  = (pcnt_q == pre_q);
  assign cnt_edge = (mode_q[0] & rise[mode_q[3:2]]) | (mode_q[1] & fall[mode_q[3:2]]);
  assign tick     = run & ((mode_q[1:0] == 2'd0) ? pre_hit : cnt_edge);

  always_comb begin
    rst_hit  = 1'b0;
    stop_hit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      eq[i]      = (cnt_q == mv_q[i]);
      rst_hit    = rst_hit | (eq[i] & mctl_q[3*i+1]);
      mint[i]    = mctl_q[3*i];
      cint[i]    = cctl_q[3*i+2];
      cap_evt[i] = (cctl_q[3*i] & rise[i]) | (cctl_q[3*i+1] & fall[i]);
    end
    cnt_inc = rst_hit ? '0 : cnt_q + 1'b1;
    for (int i = 0; i < NCH; i++) begin
      mhit[i]  = tick & (cnt_inc == mv_q[i]);
      stop_hit = stop_hit | (mhit[i] & mctl_q[3*i+2]);
    end
  end

  always_comb begin
    flg_nxt = flg_q & ~((bus_we && bus_addr == A_FLG) ? bus_wdata[2*NCH-1:0] : '0);
    flg_nxt = flg_nxt | {cap_evt & cint, mhit & mint};
  end

  always_comb begin
    ext_nxt = (bus_we && bus_addr == A_EXT) ? bus_wdata[NCH-1:0] : ext_q;
    for (int i = 0; i < NCH; i++)
      if (mhit[i])
        case (act_q[2*i +: 2])
          2'd1:    ext_nxt[i] = 1'b0;
          2'd2:    ext_nxt[i] = 1'b1;
          2'd3:    ext_nxt[i] = ~ext_nxt[i];
          default: ;
        endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      flg_q <= '0; en_q <= 1'b0; hold_q <= 1'b0;
      cnt_q <= '0; pre_q <= '0; pcnt_q <= '0;
      mctl_q <= '0; cctl_q <= '0; ext_q <= '0; act_q <= '0; mode_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        mv_q[i] <= '0;
        cv_q[i] <= '0;
      end
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      flg_q <= flg_nxt;
      ext_q <= ext_nxt;
      if (bus_we && bus_addr == A_EXT)  act_q  <= bus_wdata[4 +: 2*NCH];
      if (bus_we && bus_addr == A_CTL)  {hold_q, en_q} <= bus_wdata[1:0];
      if (stop_hit)                     en_q   <= 1'b0;
      if (bus_we && bus_addr == A_PRE)  pre_q  <= bus_wdata[CW-1:0];
      if (bus_we && bus_addr == A_MCTL) mctl_q <= bus_wdata[3*NCH-1:0];
      if (bus_we && bus_addr == A_CCTL) cctl_q <= bus_wdata[3*NCH-1:0];
      if (bus_we && bus_addr == A_MODE) mode_q <= bus_wdata[3:0];
      for (int i = 0; i < NCH; i++) begin
        if (bus_we && bus_addr == AW'(A_MV0 + AW'(i))) mv_q[i] <= bus_wdata[CW-1:0];
        if (cap_evt[i]) cv_q[i] <= cnt_q;
      end
      if (hold_q) begin
        cnt_q  <= '0;
        pcnt_q <= '0;
      end else begin
        if (bus_we && bus_addr == A_CNT) cnt_q <= bus_wdata[CW-1:0];
        else if (tick)                   cnt_q <= cnt_inc;
        if (bus_we && bus_addr == A_PCNT)          pcnt_q <= bus_wdata[CW-1:0];
        else if (run && mode_q[1:0] == 2'd0)       pcnt_q <= pre_hit ? '0 : pcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLG:   bus_rdata = 32'(flg_q);
      A_CTL:   bus_rdata = {30'd0, hold_q, en_q};
      A_CNT:   bus_rdata = 32'(cnt_q);
      A_PRE:   bus_rdata = 32'(pre_q);
      A_PCNT:  bus_rdata = 32'(pcnt_q);
      A_MCTL:  bus_rdata = 32'(mctl_q);
      A_CCTL:  bus_rdata = 32'(cctl_q);
      A_EXT:   bus_rdata = 32'({act_q, ext_q});
      A_MODE:  bus_rdata = 32'(mode_q);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(A_MV0 + AW'(i))) bus_rdata = 32'(mv_q[i]);
      if (bus_addr == AW'(A_CV0 + AW'(i))) bus_rdata = 32'(cv_q[i]);
    end
  end

  assign match_out = ext_q;
  assign irq       = |flg_q;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (cnt_q == '0 && pcnt_q == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_CNT) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_hit && !(bus_we && bus_addr == A_CNT)) |=> cnt_q == '0); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !en_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_FLG) |=> ((flg_q & $past(flg_q)) == $past(flg_q))); // R10

  for (genvar g = 0; g < NCH; g++) begin : g_capchk
    AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt[g] |=> $stable(cv_q[g])); // R8
  end
endmodule

// File: tb/tmr_match_cap_test.sv
`timescale 1ns/1ps
module tmr_match_cap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  tmr_match_cap uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  function automatic logic [31:0] exp_cnt(int k, int p);
    return 32'(k / (p + 1));
  endfunction
  function automatic logic [31:0] exp_pcnt(int k, int p);
    return 32'(k % (p + 1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = 5'(a); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(int a, output logic [31:0] d);
    addr = 5'(a); #1; d = rdata;
  endtask
  task automatic pulse(int ch, int n);
    repeat (n) begin
      @(negedge clk); cap_in[ch] = 1'b1; idle(3);
      cap_in[ch] = 1'b0; idle(3);
    end
  endtask

  initial begin
    #500us;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    for (int a = 0; a < 29; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 match_out", {28'd0, match_out}, 0);

    // R3 random divider ratios
    for (int t = 0; t < 8; t++) begin
      int p, k;
      p = int'($urandom % 5);
      k = 5 + int'($urandom % 30);
      wr(1, 2); wr(3, 32'(p)); wr(1, 1); idle(k);
      rd(2, v); chk("R3 counter", v, exp_cnt(k, p));
      rd(4, v); chk("R3 divider count", v, exp_pcnt(k, p));
    end
    // R2 hold
    wr(1, 3); idle(5);
    rd(2, v); chk("R2 counter held", v, 0);
    rd(4, v); chk("R2 divider held", v, 0);

    // R4 R6 wrap on match with flag
    begin
      int m, k;
      m = 3 + int'($urandom % 5);
      k = 2 * (m + 1) + int'($urandom % 3);
      wr(1, 2); wr(3, 0); wr(6, 32'(m)); wr(5, 3); wr(0, 32'hff); wr(1, 1);
      idle(m);
      rd(2, v); chk("R4 dwell at compare", v, 32'(m));
      idle(k - m);
      rd(2, v); chk("R4 wrap counter", v, 32'(k % (m + 1)));
      rd(0, v); chk("R6 flag 0 set", v, 1);
      chk("R10 irq high", {31'd0, irq}, 1);
      wr(1, 0); wr(0, 1);
      chk("R10 irq cleared", {31'd0, irq}, 0);
      wr(5, 0);
    end

    // R5 R6 halt on match, no flag
    wr(1, 2); wr(7, 5); wr(5, 32'h20); wr(0, 32'hff); wr(1, 1); idle(20);
    rd(2, v); chk("R5 counter halted", v, 5);
    rd(1, v); chk("R5 enable cleared", v, 0);
    rd(0, v); chk("R6 no flag when masked", v, 0);

    // R7 output actions
    wr(5, 0); wr(1, 2); wr(6, 2); wr(7, 5); wr(8, 3); wr(9, 1);
    wr(15, 32'h728);
    chk("R7 state drive", {28'd0, match_out}, 32'h8);
    wr(1, 1); idle(10); wr(1, 0);
    chk("R7 set/toggle/clear", {28'd0, match_out}, 32'h5);

    // R12 direct loads
    wr(1, 0); wr(2, 32'h1234); rd(2, v); chk("R12 counter load", v, 32'h1234);
    wr(4, 2); rd(4, v); chk("R12 divider load", v, 2);
    rd(20, v); chk("R12 unused word", v, 0);

    // R8 R9 capture
    wr(10, 32'h7a8); wr(0, 32'hff);
    @(negedge clk); cap_in[3:1] = 3'b111; idle(4);
    rd(12, v); chk("R8 rising capture ch1", v, 32'h1234);
    rd(13, v); chk("R8 rising ignored ch2", v, 0);
    rd(14, v); chk("R8 both edges rise ch3", v, 32'h1234);
    rd(0, v); chk("R9 capture flag ch1", v, 32'h20);
    wr(2, 32'h55);
    @(negedge clk); cap_in[3:1] = 3'b000; idle(4);
    rd(12, v); chk("R8 falling ignored ch1", v, 32'h1234);
    rd(13, v); chk("R8 falling capture ch2", v, 32'h55);
    rd(14, v); chk("R8 both edges fall ch3", v, 32'h55);
    rd(0, v); chk("R9 flags ch1 ch2 only", v, 32'h60);
    wr(0, 32'h20); rd(0, v); chk("R10 partial clear", v, 32'h40);
    chk("R10 irq still high", {31'd0, irq}, 1);
    wr(0, 32'h40); chk("R10 irq low", {31'd0, irq}, 0);

    // R11 edge counting on input 2
    wr(10, 0); wr(7, 0); wr(1, 2); wr(3, 7);
    wr(28, 32'h9); wr(1, 1);
    pulse(2, 4); pulse(0, 2); idle(4);
    rd(2, v); chk("R11 rising count", v, 4);
    wr(1, 2); wr(28, 32'hb); wr(1, 1);
    pulse(2, 3); pulse(1, 2); idle(4);
    rd(2, v); chk("R11 both-edge count", v, 6);
    wr(1, 2); wr(28, 32'ha); wr(1, 1);
    pulse(2, 5); idle(4);
    rd(2, v); chk("R11 falling count", v, 5);
    rd(4, v); chk("R11 divider unused", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule